// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a supervisory down counter that software must refresh before it runs out. A refresh counts only as a two-write handshake on the register port. The first write puts one fixed byte into the first key register. The second write, which must be the next register write of any kind, puts a different fixed byte into the second key register. A wrong byte, or a write to any other register between the two, abandons the handshake and leaves the counter alone. The counter steps down once per prescaler period, and the period is a power of two from 32 to 4096 clocks, so timeouts run from microseconds to seconds depending on the clock rate.

When the count is already zero and another prescaler period ends, the block raises a sticky timeout flag and reloads itself. In reset mode it also sends a one-cycle reset request. In timer mode it sends no reset request and instead holds an interrupt output while the flag is set. The counter stops when the enable bit is clear. It also stops when the clock-source select says the watchdog runs from the peripheral clock and the CPU reports power-down, because that clock is not running during power-down.

The design has two state machines. The key tracker has the states KS_IDLE and KS_ARMED. Transition *arm*: a first-key write moves KS_IDLE to KS_ARMED. Transition *rearm*: a first-key write while already in KS_ARMED stays in KS_ARMED. Transition *feed*: a correct second-key write moves KS_ARMED to KS_IDLE and reloads the counter. Transition *abort*: any other write moves KS_ARMED to KS_IDLE. The run controller has the states RS_OFF, RS_PAUSED and RS_RUN. It goes to RS_OFF when the enable bit is clear, to RS_PAUSED when the clock is gated, and to RS_RUN otherwise. It re-evaluates this choice every clock.

Top module: `kwdt_top`

## Requirements
- R1: After reset the count is RELOAD_RST (255 by default). The timeout flag, reset request and interrupt are all 0. The block is enabled, in reset mode, with divide select 0. The run controller enters RS_RUN one cycle after reset is released.
- R2: A write of A5h to address 2 followed by a write of 5Ah to address 3 reloads the count from the reload register and clears the prescaler. The new count is visible in the cycle after the second write. The second write must be the next register write, but idle cycles between the two writes are allowed.
- R3: A wrong byte in either write does not reload the count, and the handshake returns to idle. A wrong first write leaves it idle. A wrong second write aborts it.
- R4: Any write to address 0, 1 or 3 between the two key writes cancels the handshake. A repeated A5h write to address 2 restarts it. One completed handshake never yields two reloads.
- R5: While running, the count drops by one at the end of each prescaler period of 2^(5+S) clocks. S is the control field at address 0, bits [2:0].
- R6: When a prescaler period ends with the count at 0, the count reloads and the timeout flag sets. With control bit 3 = 1 (reset mode), the reset request is high for exactly the following cycle.
- R7: With control bit 3 = 0 (timer mode), no reset request is made and the interrupt output equals the timeout flag. Writing address 0 with bit 5 = 1 clears the flag, unless a timeout occurs in the same cycle.
- R8: With control bit 4 (enable) = 0, the count and the prescaler hold from the next cycle on. A feed still reloads the count.
- R9: With clk_sel = 1 and cpu_pd = 1 together, the count holds from the next cycle on. Either input alone does not stop the count.
- R10: A write to address 1 sets the reload value used by later feeds and timeouts.
- R11: If a feed and a timeout fall in the same cycle, the feed wins. The count takes the reload value and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 1 = watchdog clocked from the peripheral clock |
| cpu_pd | input | 1 | 1 = CPU is powered down |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 reload, 2 first key, 3 second key |
| wr_data | input | 8 | Write data |
| count_o | output | CNT_W | Current down-counter value |
| tmo_flag | output | 1 | Sticky timeout flag |
| rst_req | output | 1 | One-cycle reset request (reset mode) |
| irq | output | 1 | Timeout interrupt (timer mode) |

## Verification
The assertions assume that clk_sel and cpu_pd are steady around the clock edge. They also assume the reload value and divide select are written only through the register port, never forced. The one-cycle reset pulse property relies on a prescaler period of at least 32 clocks, so two timeouts can never fall on adjacent cycles.

The stimulus drives inputs only on falling edges. It includes back-to-back key writes, key writes split by idle cycles, and key writes split by other writes. It also sweeps feed timing across a whole prescaler period, so that some feeds land exactly on a timeout tick.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int BYTE_W = 8;

    // register addresses
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_KEY1   = 2'd2;
    localparam logic [1:0] ADDR_KEY2   = 2'd3;

    // key bytes, in the order they must arrive
    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'hA5;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'h5A;

    // control register bit positions
    localparam int CTL_SEL_LSB = 0;
    localparam int CTL_MODE    = 3;
    localparam int CTL_EN      = 4;
    localparam int CTL_CLR     = 5;

    typedef enum logic {
        KS_IDLE,
        KS_ARMED
    } key_st_e;

    typedef enum logic [1:0] {
        RS_OFF,
        RS_PAUSED,
        RS_RUN
    } run_st_e;

endpackage

// File: rtl/kwdt_key_seq.sv
module kwdt_key_seq
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              feed_ok
);

    key_st_e st_q;
    key_st_e st_d;
    logic    hit_first;
    logic    hit_second;

    assign hit_first  = (wr_addr == ADDR_KEY1) && (wr_data == KEY_FIRST);
    assign hit_second = (wr_addr == ADDR_KEY2) && (wr_data == KEY_SECOND);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= KS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: arm, rearm, feed, abort
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KS_IDLE: begin
                if (wr_en && hit_first) begin
                    st_d = KS_ARMED;
                end
            end
            KS_ARMED: begin
                if (wr_en) begin
                    st_d = hit_first ? KS_ARMED : KS_IDLE;
                end
            end
            default: st_d = KS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        feed_ok = 1'b0;
        unique case (st_q)
            KS_IDLE:  feed_ok = 1'b0;
            KS_ARMED: feed_ok = wr_en && hit_second;
            default:  feed_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
    parameter int SEL_W      = 3,
    parameter int PS_MIN_LOG = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int PS_W = PS_MIN_LOG + (1 << SEL_W) - 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] limit;

    always_comb begin
        limit = PS_W'((64'd1 << (PS_MIN_LOG + int'(sel))) - 64'd1);
    end

    // greater-or-equal so that a smaller divide picked mid-period ends it at once
    assign tick = run && (ps_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (clr) begin
            ps_q <= '0;
        end else if (run) begin
            ps_q <= tick ? '0 : ps_q + 1'b1;
        end
    end

endmodule

// File: rtl/kwdt_down_cnt.sv
module kwdt_down_cnt
    import kwdt_pkg::*;
#(
    parameter int                CNT_W      = 8,
    parameter logic [CNT_W-1:0]  RELOAD_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             gate,
    input  logic             feed,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             run,
    output logic             expire
);

    run_st_e         st_q;
    run_st_e         st_d;
    logic [CNT_W-1:0] cnt_q;

    // run-state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RS_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_OFF, RS_PAUSED, RS_RUN: begin
                if (!en) begin
                    st_d = RS_OFF;
                end else if (gate) begin
                    st_d = RS_PAUSED;
                end else begin
                    st_d = RS_RUN;
                end
            end
            default: st_d = RS_OFF;
        endcase
    end

    // outputs of the run controller
    always_comb begin
        run = 1'b0;
        unique case (st_q)
            RS_RUN:            run = 1'b1;
            RS_OFF, RS_PAUSED: run = 1'b0;
            default:           run = 1'b0;
        endcase
    end

    assign expire = tick && (cnt_q == '0) && !feed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD_RST;
        end else if (feed) begin
            cnt_q <= reload;
        end else if (tick) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int               CNT_W      = 8,
    parameter int               SEL_W      = 3,
    parameter int               PS_MIN_LOG = 5,
    parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_sel,
    input  logic              cpu_pd,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count_o,
    output logic              tmo_flag,
    output logic              rst_req,
    output logic              irq
);

    logic             en_q;
    logic             mode_rst_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] reload_q;
    logic             flag_q;
    logic             rst_q;

    logic feed_ok;
    logic tick;
    logic cnt_run;
    logic expire;
    logic ctrl_wr;
    logic gate;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign gate    = clk_sel && cpu_pd;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b1;
            mode_rst_q <= 1'b1;
            sel_q      <= '0;
            reload_q   <= RELOAD_RST;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                en_q       <= wr_data[CTL_EN];
                mode_rst_q <= wr_data[CTL_MODE];
                sel_q      <= wr_data[CTL_SEL_LSB +: SEL_W];
            end else if (wr_addr == ADDR_RELOAD) begin
                reload_q   <= CNT_W'(wr_data);
            end
        end
    end

    // timeout flag and reset pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            rst_q  <= 1'b0;
        end else begin
            rst_q <= expire && mode_rst_q;
            if (expire) begin
                flag_q <= 1'b1;
            end else if (ctrl_wr && wr_data[CTL_CLR]) begin
                flag_q <= 1'b0;
            end
        end
    end

    kwdt_key_seq u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .feed_ok (feed_ok)
    );

    kwdt_prescale #(
        .SEL_W      (SEL_W),
        .PS_MIN_LOG (PS_MIN_LOG)
    ) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cnt_run),
        .clr   (feed_ok),
        .sel   (sel_q),
        .tick  (tick)
    );

    kwdt_down_cnt #(
        .CNT_W      (CNT_W),
        .RELOAD_RST (RELOAD_RST)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_q),
        .gate   (gate),
        .feed   (feed_ok),
        .tick   (tick),
        .reload (reload_q),
        .count  (count_o),
        .run    (cnt_run),
        .expire (expire)
    );

    assign tmo_flag = flag_q;
    assign rst_req  = rst_q;
    assign irq      = flag_q && !mode_rst_q;

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_sel,
    input logic             cpu_pd,
    input logic             feed_ok,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic             rst_req,
    input logic             flag,
    input logic             irq
);

    AST_FEED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        feed_ok |=> (count == $past(reload))); // R2

    AST_NO_DOUBLE_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        feed_ok |=> !feed_ok); // R4

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R6

    AST_RST_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> flag); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R7

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !feed_ok) |=> $stable(count)); // R8

    AST_GATED_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel && cpu_pd) |=> !run); // R9

endmodule

bind kwdt_top kwdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_sel (clk_sel),
    .cpu_pd  (cpu_pd),
    .feed_ok (feed_ok),
    .run     (cnt_run),
    .count   (count_o),
    .reload  (reload_q),
    .rst_req (rst_req),
    .flag    (flag_q),
    .irq     (irq)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_sel = 1'b0;
    logic             cpu_pd = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [7:0]       wr_data = 8'd0;
    logic [CNT_W-1:0] count_o;
    logic             tmo_flag;
    logic             rst_req;
    logic             irq;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // behavioural model state
    int m_cnt, m_ps, m_reload, m_sel;
    bit m_en, m_mode, m_run, m_flag, m_rst, m_armed;

    always #(CLK_PERIOD/2) clk = ~clk;

    kwdt_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_sel  (clk_sel),
        .cpu_pd   (cpu_pd),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .count_o  (count_o),
        .tmo_flag (tmo_flag),
        .rst_req  (rst_req),
        .irq      (irq)
    );

    // reference model, updated on each rising edge from the current inputs
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 255; m_ps = 0; m_reload = 255; m_sel = 0;
            m_en = 1; m_mode = 1; m_run = 0; m_flag = 0; m_rst = 0; m_armed = 0;
        end else begin
            bit feed, tick, expire, n_armed;
            int lim;
            feed   = m_armed && wr_en && wr_addr == 2'd3 && wr_data == 8'h5A;
            n_armed = wr_en ? (wr_addr == 2'd2 && wr_data == 8'hA5) : m_armed;
            lim    = (1 << (5 + m_sel)) - 1;
            tick   = m_run && (m_ps >= lim);
            expire = tick && (m_cnt == 0) && !feed;
            m_rst  = expire && m_mode;
            if (expire) m_flag = 1;
            else if (wr_en && wr_addr == 2'd0 && wr_data[5]) m_flag = 0;
            if (feed) m_ps = 0;
            else if (m_run) m_ps = tick ? 0 : m_ps + 1;
            if (feed) m_cnt = m_reload;
            else if (tick) m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
            m_run   = m_en && !(clk_sel && cpu_pd);
            m_armed = n_armed;
            if (wr_en && wr_addr == 2'd0) begin
                m_en = wr_data[4]; m_mode = wr_data[3]; m_sel = int'(wr_data[2:0]);
            end
            if (wr_en && wr_addr == 2'd1) m_reload = int'(wr_data);
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // every-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R5 count", int'(count_o), m_cnt);
            cmp("R6 rst_req", int'(rst_req), int'(m_rst));
            cmp("R6 flag", int'(tmo_flag), int'(m_flag));
            cmp("R7 irq", int'(irq), int'(m_flag && !m_mode));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hang expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cmp("R1 count", int'(count_o), 255);
        cmp("R1 flag", int'(tmo_flag), 0);
        cmp("R1 rst_req", int'(rst_req), 0);
        cmp("R1 irq", int'(irq), 0);
        idle(100);                               // R5 at divide 32

        // R10 + R2: reload 3, back-to-back key writes
        wr(2'd1, 8'd3);
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h5A);
        idle(1);
        cmp("R2 reload", int'(count_o), 3);
        idle(20);

        // R3: wrong first byte, then wrong second byte
        wr(2'd1, 8'd9);
        wr(2'd2, 8'h55); wr(2'd3, 8'h5A); idle(1);
        cmp("R3 wrong first", int'(count_o), m_cnt);
        wr(2'd2, 8'hA5); wr(2'd3, 8'h5B); wr(2'd3, 8'h5A); idle(1);
        cmp("R3 wrong second", int'(count_o), m_cnt);

        // R4: intervening write cancels, idle cycles do not, rearm works
        wr(2'd2, 8'hA5); wr(2'd0, 8'h18); wr(2'd3, 8'h5A); idle(1);
        cmp("R4 cancel", int'(count_o), m_cnt);
        wr(2'd2, 8'hA5); idle(5); wr(2'd3, 8'h5A); idle(1);
        cmp("R4 gap feed", int'(count_o), 9);
        wr(2'd2, 8'hA5); wr(2'd2, 8'hA5); wr(2'd3, 8'h5A); idle(1);
        cmp("R4 rearm", int'(count_o), 9);

        // R6: let it expire in reset mode
        wr(2'd1, 8'd2); wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
        idle(400);

        // R7: timer mode, interrupt, clear
        wr(2'd0, 8'h10);
        idle(300);
        cmp("R7 irq set", int'(irq), 1);
        wr(2'd0, 8'h30); idle(1);
        cmp("R7 cleared", int'(tmo_flag), int'(m_flag));
        idle(50);

        // R8: disabled
        wr(2'd0, 8'h00); idle(200);
        cmp("R8 hold", int'(count_o), m_cnt);
        wr(2'd2, 8'hA5); wr(2'd3, 8'h5A); idle(1);
        cmp("R8 feed while off", int'(count_o), 2);

        // R9: clock gating
        wr(2'd0, 8'h18);
        clk_sel = 1'b1; idle(100);
        cpu_pd = 1'b1; idle(200);
        cmp("R9 gated", int'(count_o), m_cnt);
        clk_sel = 1'b0; idle(100);
        cpu_pd = 1'b0;

        // R5: divide 128
        wr(2'd0, 8'h1A); wr(2'd1, 8'd5);
        wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
        idle(1000);

        // R11: feeds at every phase of a period, reload 0 so ticks expire
        wr(2'd0, 8'h18); wr(2'd1, 8'd0);
        for (int g = 0; g < 40; g++) begin
            wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
            idle(g + 1);
        end
        cmp("R11 flag", int'(tmo_flag), int'(m_flag));

        // R5: divide 4096
        wr(2'd0, 8'h1F); wr(2'd1, 8'd1);
        wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
        idle(13000);
        cmp("R6 long flag", int'(tmo_flag), 1);

        summary();
    end

endmodule